// File: doc/BRIEF.md
# Signed Radix-4 Booth Multiplier with Weight-Based Operand Exchange

This block multiplies two signed two's-complement operands and returns the exact double-width product. The core is a radix-4 Booth multiplier. Before any partial products are formed, the block counts the nonzero Booth digits that each operand would produce if it were the recoded one. The operand with the smaller count goes to the recoder, and the other becomes the multiplicand. The product is the same either way. What changes is how many partial-product rows are actually added, and with it how much the adder tree toggles.

Operation is a plain pipeline. A result appears exactly three cycles after the operands are accepted, and a new pair may be presented every cycle. Beside the product, the block reports two things: whether the operands were exchanged, and how many partial-product rows were active. This makes the power-saving decision visible at the ports. Results stay on the outputs until the next one replaces them.

Top module: `booth_swap_mult`

## Requirements
- R1: For every pair of signed W-bit inputs, `out_product` equals the exact signed product `in_a * in_b` as a 2W-bit two's-complement value.
- R2: An input pair accepted with `in_valid`=1 produces exactly one cycle of `out_valid`=1, three rising edges later. Back-to-back pairs on consecutive cycles each produce their own result, in order.
- R3: The weight of an operand y is the number of nonzero digits d_i = y[2i] + y[2i-1] - 2*y[2i+1], for i = 0 .. W/2-1, taking y[-1] = 0. `out_pp_count` reports the weight of the operand that was recoded, and it never exceeds W/2.
- R4: If weight(`in_a`) < weight(`in_b`), then `in_a` is recoded and `out_swapped`=1. If weight(`in_b`) < weight(`in_a`), then `in_b` is recoded and `out_swapped`=0. In both cases `out_pp_count` equals the smaller weight.
- R5: If the two weights are equal, no exchange takes place: `out_swapped`=0 and `in_b` is the recoded operand.
- R6: A zero Booth digit contributes no partial product. When `out_pp_count` is 0, `out_product` is 0.
- R7: The most negative input squared, -2^(W-1) * -2^(W-1), gives +2^(2W-2) with no overflow.
- R8: While `rst_n`=0, `out_valid`, `out_product`, `out_swapped` and `out_pp_count` are all 0.
- R9: While `out_valid`=0, `out_product`, `out_swapped` and `out_pp_count` keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair valid this cycle |
| in_a | input | W | First signed operand |
| in_b | input | W | Second signed operand |
| out_valid | output | 1 | Result valid, one cycle per accepted pair |
| out_product | output | 2W | Signed product |
| out_swapped | output | 1 | 1 when `in_a` was the recoded operand |
| out_pp_count | output | clog2(W/2+1) | Number of active partial-product rows |

## Verification
The bench builds one instance with W=8. Every one of the 65,536 signed operand pairs is streamed through it back to back. At that width, every tie, every swap direction, every zero-weight operand and the -128 squared corner are reached, and each pair's product, exchange flag and row count are compared against values computed arithmetically. A second instance at the default W=16 gets directed pairs: the most negative square, a low-weight operand against an alternating-bit operand, tied weights, and zero. Isolated pulses and idle gaps check the three-cycle latency and that results are held between pulses.

// File: rtl/booth_swap_mult.sv
module booth_swap_mult #(
  parameter int W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [W-1:0]                  in_a,
  input  logic [W-1:0]                  in_b,
  output logic                          out_valid,
  output logic [2*W-1:0]                out_product,
  output logic                          out_swapped,
  output logic [$clog2(W/2+1)-1:0]      out_pp_count
);
  localparam int NDIG = W / 2;
  localparam int PW   = 2 * W;
  localparam int CW   = $clog2(NDIG + 1);

  function automatic logic [CW-1:0] digit_weight(input logic [W-1:0] v);
    logic [W:0]    ext;
    logic [CW-1:0] cnt;
    ext = {v, 1'b0};
    cnt = '0;
    for (int i = 0; i < NDIG; i++)
      if (ext[2*i+2 -: 3] != 3'b000 && ext[2*i+2 -: 3] != 3'b111)
        cnt = cnt + 1'b1;
    return cnt;
  endfunction

  // stage 1: operands and their weights
  logic          v1;
  logic [W-1:0]  a1, b1;
  logic [CW-1:0] wa1, wb1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1  <= 1'b0;
      a1  <= '0;
      b1  <= '0;
      wa1 <= '0;
      wb1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        a1  <= in_a;
        b1  <= in_b;
        wa1 <= digit_weight(in_a);
        wb1 <= digit_weight(in_b);
      end
    end
  end

  // stage 2: registered comparison and routing
  logic          v2, sw2;
  logic [W-1:0]  x2, y2;
  logic [CW-1:0] wr2;
  wire           take_a = wa1 < wb1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2  <= 1'b0;
      sw2 <= 1'b0;
      x2  <= '0;
      y2  <= '0;
      wr2 <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        sw2 <= take_a;
        x2  <= take_a ? b1 : a1;
        y2  <= take_a ? a1 : b1;
        wr2 <= take_a ? wa1 : wb1;
      end
    end
  end

  // stage 3: recoding, partial products, sum
  wire  [W:0]    y_ext  = {y2, 1'b0};
  wire  [PW-1:0] x_ext  = {{W{x2[W-1]}}, x2};
  wire  [PW-1:0] x_dbl  = x_ext << 1;
  logic [PW-1:0] pp [NDIG];

  for (genvar g = 0; g < NDIG; g++) begin : g_row
    wire [2:0]    trip = y_ext[2*g+2 -: 3];
    wire [PW-1:0] mag  = (trip == 3'b011 || trip == 3'b100) ? x_dbl : x_ext;
    wire          neg  = trip[2];
    wire          zero = (trip == 3'b000) || (trip == 3'b111);
    assign pp[g] = zero ? '0 : ((neg ? (~mag + 1'b1) : mag) << (2*g));
  end

  logic [PW-1:0] pp_sum;
  always_comb begin
    pp_sum = '0;
    for (int i = 0; i < NDIG; i++)
      pp_sum = pp_sum + pp[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_product  <= '0;
      out_swapped  <= 1'b0;
      out_pp_count <= '0;
    end else begin
      out_valid <= v2;
      if (v2) begin
        out_product  <= pp_sum;
        out_swapped  <= sw2;
        out_pp_count <= wr2;
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid); // R2

  AST_LOWER_RECODED: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> digit_weight(y2) == (($past(wa1) < $past(wb1)) ? $past(wa1) : $past(wb1))); // R4

  AST_TIE_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && wa1 == wb1) |=> !sw2); // R5

  AST_ZERO_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pp_count == '0) |-> out_product == '0); // R6

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pp_count <= CW'(NDIG)); // R3

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_product) && $stable(out_swapped) && $stable(out_pp_count))); // R9
endmodule

// File: tb/tb_booth_swap_mult.sv
module tb_booth_swap_mult;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic       rst_n = 1'b0;
  logic       v8 = 1'b0, v16 = 1'b0;
  logic [7:0] a8 = '0, b8 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic       ov8, ov16, sw8, sw16;
  logic [15:0] p8;
  logic [31:0] p16;
  logic [2:0] c8;
  logic [3:0] c16;

  booth_swap_mult #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_a(a8), .in_b(b8),
    .out_valid(ov8), .out_product(p8), .out_swapped(sw8), .out_pp_count(c8));

  booth_swap_mult #(.W(16)) dut16 (
    .clk(clk), .rst_n(rst_n), .in_valid(v16), .in_a(a16), .in_b(b16),
    .out_valid(ov16), .out_product(p16), .out_swapped(sw16), .out_pp_count(c16));

  function automatic int bw(input logic [15:0] v, input int n);
    int c = 0;
    for (int i = 0; i < n / 2; i++) begin
      int d;
      d = int'(v[2*i]) - 2 * int'(v[2*i+1]) + ((i == 0) ? 0 : int'(v[2*i-1]));
      if (d != 0) c++;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  longint qp[$];
  int     qs[$];
  int     qc[$];
  int     nout = 0;

  always @(negedge clk) begin
    if (rst_n && ov8) begin
      nout++;
      if (qp.size() == 0) chk(0, "R2", "result without input", 1, 0);
      else begin
        longint ep; int es; int ec;
        ep = qp.pop_front(); es = qs.pop_front(); ec = qc.pop_front();
        chk(longint'($signed(p8)) == ep, "R1", "product", longint'($signed(p8)), ep);
        chk(int'(sw8) == es, (bw({8'd0, a8}, 8) == bw({8'd0, b8}, 8)) ? "R5" : "R4",
            "swapped", sw8, es);
        chk(int'(c8) == ec, "R3", "pp_count", c8, ec);
        if (ec == 0) chk(p8 == '0, "R6", "zero-weight product", longint'($signed(p8)), 0);
      end
    end
  end

  task automatic push8(input logic [7:0] a, input logic [7:0] b);
    int wa, wb;
    wa = bw({8'd0, a}, 8);
    wb = bw({8'd0, b}, 8);
    qp.push_back(longint'($signed(a)) * longint'($signed(b)));
    qs.push_back((wa < wb) ? 1 : 0);
    qc.push_back((wa < wb) ? wa : wb);
  endtask

  task automatic run16(input logic [15:0] a, input logic [15:0] b, input string tag);
    int wa, wb;
    longint ep;
    wa = bw(a, 16);
    wb = bw(b, 16);
    ep = longint'($signed(a)) * longint'($signed(b));
    @(negedge clk);
    a16 = a; b16 = b; v16 = 1'b1;
    @(negedge clk);
    v16 = 1'b0;
    repeat (2) @(negedge clk);
    chk(ov16 == 1'b1, "R2", "w16 out_valid", ov16, 1);
    chk(longint'($signed(p16)) == ep, tag, "w16 product", longint'($signed(p16)), ep);
    chk(int'(sw16) == ((wa < wb) ? 1 : 0), (wa == wb) ? "R5" : "R4", "w16 swapped",
        sw16, (wa < wb) ? 1 : 0);
    chk(int'(c16) == ((wa < wb) ? wa : wb), "R3", "w16 pp_count", c16, (wa < wb) ? wa : wb);
    @(negedge clk);
    chk(ov16 == 1'b0, "R2", "w16 single pulse", ov16, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(ov8 == 0 && ov16 == 0, "R8", "out_valid in reset", ov8 | ov16, 0);
    chk(p8 == 0 && p16 == 0, "R8", "product in reset", p8 | p16, 0);
    chk(sw8 == 0 && c8 == 0 && sw16 == 0 && c16 == 0, "R8", "flags in reset", sw8 | sw16, 0);
    rst_n = 1'b1;

    // R2: isolated pulse latency
    @(negedge clk);
    a8 = 8'd3; b8 = 8'hFB; v8 = 1'b1; push8(a8, b8);
    @(negedge clk);
    v8 = 1'b0;
    chk(ov8 == 0, "R2", "valid after 1 edge", ov8, 0);
    @(negedge clk);
    chk(ov8 == 0, "R2", "valid after 2 edges", ov8, 0);
    @(negedge clk);
    chk(ov8 == 1, "R2", "valid after 3 edges", ov8, 1);
    @(negedge clk);
    chk(ov8 == 0, "R2", "valid after 4 edges", ov8, 0);

    // exhaustive sweep, back to back
    for (int ia = 0; ia < 256; ia++)
      for (int ib = 0; ib < 256; ib++) begin
        @(negedge clk);
        a8 = ia[7:0]; b8 = ib[7:0]; v8 = 1'b1;
        push8(a8, b8);
      end
    @(negedge clk);
    v8 = 1'b0;
    repeat (5) @(negedge clk);
    chk(qp.size() == 0, "R2", "pending results", qp.size(), 0);
    chk(nout == 65537, "R2", "result count", nout, 65537);

    // R9: hold after last result (-1 * -1, weights equal 1)
    for (int k = 0; k < 3; k++) begin
      a8 = 8'h55; b8 = 8'hAA;
      chk(ov8 == 0 && $signed(p8) == 1, "R9", "held product", longint'($signed(p8)), 1);
      chk(sw8 == 0 && c8 == 1, "R9", "held count", c8, 1);
      @(negedge clk);
    end

    // wide instance, directed corners
    run16(16'h8000, 16'h8000, "R7");
    run16(16'h003C, 16'hAAAA, "R1");
    run16(16'hAAAA, 16'h003C, "R1");
    run16(16'h003C, 16'h7FFF, "R1");
    run16(16'h0000, 16'h1234, "R6");
    run16(16'hFFFF, 16'h8001, "R1");
    run16(16'h7FFF, 16'h8000, "R1");
    chk(bw(16'h003C, 16) == 2, "R3", "bench weight of 0x3C", bw(16'h003C, 16), 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule